// File: doc/BRIEF.md
# Two-Wire DAC Code Register Bank with Reset Commands

This block is a write-only target on a two-wire serial bus. It holds one code register per DAC channel and presents every code at once on a flat parallel output. A controller addresses the target and sends a command byte that names a channel. A plain write then sends two data bytes that make up the new code. The command byte can also return the whole bank, or one channel, to the mid-scale code. The target also answers the bus-wide general-call address. When a general-call reset follows that address, the target resets itself completely.

The bus lines come in asynchronous. Each is passed through a two-stage synchronizer and sampled on the system clock, which must run well above the bus clock. The target answers each byte by pulling its open-drain data line low, using an output-enable. Power-on reset and general-call reset leave every channel at mid-scale, which is half of full scale.

Top module: `dacbank_i2c_target`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, every channel reads the mid-scale code 10'h200 and `sda_oe_o` is 0.
- R2: The address byte 0x00 is always acknowledged. If the next byte is 0x06, it is acknowledged. At the SCL falling edge that ends that acknowledge, every channel returns to 10'h200 and the target goes idle.
- R3: After address 0x00, any data byte other than 0x06 is not acknowledged and changes no channel.
- R4: The command byte is decoded as follows. Bits 7:5 are the command: 000 write, 100 reset all, 010 reset one. Bit 4 must be 0. Bits 3:0 are the channel, which must be below the channel count (8). Any other command byte is not acknowledged, and no further byte is acknowledged until a START or STOP.
- R5: A command byte with bits 7:5 = 100 sets every channel to 10'h200 as soon as its eighth bit is taken. The two bytes after it are acknowledged and then thrown away.
- R6: A command byte with bits 7:5 = 010 sets only the named channel to 10'h200. The two bytes after it are acknowledged and do not change any channel.
- R7: A write command byte is followed by a high byte and then a low byte. Bits 1:0 of the high byte become code bits 9:8, and bits 7:2 of the high byte are ignored. The low byte becomes code bits 7:0. The channel takes the new code after the low byte's acknowledge ends. No other channel changes.
- R8: After a low byte, the next byte is decoded as a new command byte, with no new START needed.
- R9: The address byte is the 7-bit address in bits 7:1 and the direction in bit 0. It is acknowledged only when the address equals `DEV_ADDR` and bit 0 is 0. Otherwise it is not acknowledged, and neither is any byte after it.
- R10: A START or STOP at any point ends the transfer in progress. A write that has not reached its low-byte acknowledge leaves the channel unchanged. After a START, the next byte is decoded as an address.
- R11: The acknowledge pulls SDA low from the SCL falling edge after the eighth bit until the next SCL falling edge. At all other times SDA is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high power-on reset |
| scl_i | input | 1 | Bus clock line, asynchronous |
| sda_i | input | 1 | Bus data line as seen on the wire, asynchronous |
| sda_oe_o | output | 1 | 1 pulls the data line low (open drain) |
| codes_o | output | NCH*CW (80) | Channel codes; channel k is bits k*CW +: CW |

## Verification
A wrong stage or a wrong bit count inside the target shows up as a misplaced or missing acknowledge. The controller sees this on SDA in the ninth clock of the very byte where the state went wrong. A wrong decode of a command or of general-call data shows up on `codes_o` a few system clocks after that byte's eighth bit or after its acknowledge. So the bench compares the whole bank after each transfer and in the middle of the reset-all transfer, and it checks the acknowledge of every byte it sends.

// File: rtl/dacbank_pkg.sv
package dacbank_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_SEL, ST_MSB, ST_LSB, ST_GCDATA, ST_SKIP
  } stage_t;

  typedef enum logic [1:0] {
    PH_BITS, PH_WAITFALL, PH_ACK
  } phase_t;

  typedef enum logic [1:0] {
    ACT_NONE, ACT_WRITE, ACT_GCRST
  } act_t;

  localparam logic [2:0] CMD_WRITE = 3'b000;
  localparam logic [2:0] CMD_ALL   = 3'b100;
  localparam logic [2:0] CMD_ONE   = 3'b010;
  localparam logic [7:0] GC_ADDR   = 8'h00;
  localparam logic [7:0] GC_RESET  = 8'h06;
endpackage

// File: rtl/dacbank_linesync.sv
module dacbank_linesync #(
  parameter int SYNC = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [SYNC:0] scl_q, sda_q;
  logic scl_now, scl_old, sda_now, sda_old;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= '1;
      sda_q <= '1;
    end else begin
      scl_q <= {scl_q[SYNC-1:0], scl_i};
      sda_q <= {sda_q[SYNC-1:0], sda_i};
    end
  end

  assign scl_now   = scl_q[SYNC-1];
  assign scl_old   = scl_q[SYNC];
  assign sda_now   = sda_q[SYNC-1];
  assign sda_old   = sda_q[SYNC];
  assign sda_s     = sda_now;
  assign scl_rise  = scl_now & ~scl_old;
  assign scl_fall  = ~scl_now & scl_old;
  assign start_det = scl_now & scl_old & sda_old & ~sda_now;
  assign stop_det  = scl_now & scl_old & ~sda_old & sda_now;
endmodule

// File: rtl/dacbank_proto.sv
module dacbank_proto
  import dacbank_pkg::*;
#(
  parameter int         NCH      = 8,
  parameter int         CW       = 10,
  parameter logic [6:0] DEV_ADDR = 7'h2A,
  localparam int        CHW      = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int        MSBW     = CW - 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           sda_s,
  input  logic           scl_rise,
  input  logic           scl_fall,
  input  logic           start_det,
  input  logic           stop_det,
  output logic           sda_oe,
  output logic           clear_all,
  output logic           clear_one,
  output logic [CHW-1:0] clear_idx,
  output logic           wr_en,
  output logic [CHW-1:0] wr_idx,
  output logic [CW-1:0]  wr_data,
  output logic           full_rst
);
  stage_t            stage, dec_nxt, nxt_q;
  phase_t            phase;
  act_t              dec_act, act_q;
  logic [2:0]        bitcnt;
  logic [6:0]        sr;
  logic [7:0]        rx;
  logic              dec_ack, dec_ca, dec_co, ack_ok, drop_q, sel_ok;
  logic [CHW-1:0]    ch_q;
  logic [MSBW-1:0]   msb_q;

  assign rx     = {sr, sda_s};
  assign wr_idx = ch_q;
  assign sel_ok = (rx[4] == 1'b0) && (int'(rx[3:0]) < NCH) &&
                  (rx[7:5] == CMD_WRITE || rx[7:5] == CMD_ALL || rx[7:5] == CMD_ONE);

  always_comb begin
    dec_ack = 1'b0;
    dec_nxt = ST_SKIP;
    dec_act = ACT_NONE;
    dec_ca  = 1'b0;
    dec_co  = 1'b0;
    case (stage)
      ST_ADDR: begin
        if (rx == GC_ADDR) begin
          dec_ack = 1'b1;
          dec_nxt = ST_GCDATA;
        end else if (rx == {DEV_ADDR, 1'b0}) begin
          dec_ack = 1'b1;
          dec_nxt = ST_SEL;
        end
      end
      ST_GCDATA: begin
        if (rx == GC_RESET) begin
          dec_ack = 1'b1;
          dec_act = ACT_GCRST;
          dec_nxt = ST_IDLE;
        end
      end
      ST_SEL: begin
        if (sel_ok) begin
          dec_ack = 1'b1;
          dec_nxt = ST_MSB;
          dec_ca  = (rx[7:5] == CMD_ALL);
          dec_co  = (rx[7:5] == CMD_ONE);
        end
      end
      ST_MSB: begin
        dec_ack = 1'b1;
        dec_nxt = ST_LSB;
      end
      ST_LSB: begin
        dec_ack = 1'b1;
        dec_nxt = ST_SEL;
        dec_act = drop_q ? ACT_NONE : ACT_WRITE;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || full_rst) begin
      stage     <= ST_IDLE;
      phase     <= PH_BITS;
      bitcnt    <= '0;
      sr        <= '0;
      sda_oe    <= 1'b0;
      ack_ok    <= 1'b0;
      nxt_q     <= ST_IDLE;
      act_q     <= ACT_NONE;
      drop_q    <= 1'b0;
      ch_q      <= '0;
      msb_q     <= '0;
      clear_all <= 1'b0;
      clear_one <= 1'b0;
      clear_idx <= '0;
      wr_en     <= 1'b0;
      wr_data   <= '0;
      full_rst  <= 1'b0;
    end else begin
      clear_all <= 1'b0;
      clear_one <= 1'b0;
      wr_en     <= 1'b0;
      if (start_det) begin
        stage  <= ST_ADDR;
        phase  <= PH_BITS;
        bitcnt <= '0;
        sda_oe <= 1'b0;
      end else if (stop_det) begin
        stage  <= ST_IDLE;
        phase  <= PH_BITS;
        bitcnt <= '0;
        sda_oe <= 1'b0;
      end else if (stage != ST_IDLE) begin
        case (phase)
          PH_BITS: if (scl_rise) begin
            sr <= rx[6:0];
            if (bitcnt == 3'd7) begin
              bitcnt    <= '0;
              phase     <= PH_WAITFALL;
              ack_ok    <= dec_ack;
              nxt_q     <= dec_nxt;
              act_q     <= dec_act;
              clear_all <= dec_ca;
              clear_one <= dec_co;
              if (stage == ST_SEL) begin
                ch_q      <= rx[CHW-1:0];
                clear_idx <= rx[CHW-1:0];
                drop_q    <= (rx[7:5] != CMD_WRITE);
              end
              if (stage == ST_MSB) msb_q <= rx[MSBW-1:0];
              if (stage == ST_LSB) wr_data <= {msb_q, rx};
            end else begin
              bitcnt <= bitcnt + 3'd1;
            end
          end
          PH_WAITFALL: if (scl_fall) begin
            sda_oe <= ack_ok;
            phase  <= PH_ACK;
          end
          default: if (scl_fall) begin
            sda_oe   <= 1'b0;
            phase    <= PH_BITS;
            stage    <= nxt_q;
            wr_en    <= (act_q == ACT_WRITE);
            full_rst <= (act_q == ACT_GCRST);
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/dacbank_regs.sv
module dacbank_regs #(
  parameter int  NCH = 8,
  parameter int  CW  = 10,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wipe,
  input  logic              clear_all,
  input  logic              clear_one,
  input  logic [CHW-1:0]    clear_idx,
  input  logic              wr_en,
  input  logic [CHW-1:0]    wr_idx,
  input  logic [CW-1:0]     wr_data,
  output logic [NCH*CW-1:0] codes_o
);
  localparam logic [CW-1:0] MID = {1'b1, {(CW-1){1'b0}}};

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    always_ff @(posedge clk) begin
      if (rst || wipe || clear_all || (clear_one && clear_idx == CHW'(g)))
        codes_o[g*CW +: CW] <= MID;
      else if (wr_en && wr_idx == CHW'(g))
        codes_o[g*CW +: CW] <= wr_data;
    end
  end
endmodule

// File: rtl/dacbank_i2c_target.sv
module dacbank_i2c_target #(
  parameter int         NCH      = 8,
  parameter int         CW       = 10,
  parameter logic [6:0] DEV_ADDR = 7'h2A,
  parameter int         SYNC     = 2,
  localparam int        CHW      = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  output logic [NCH*CW-1:0] codes_o
);
  logic           sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic           clear_all, clear_one, wr_en, full_rst;
  logic [CHW-1:0] clear_idx, wr_idx;
  logic [CW-1:0]  wr_data;

  dacbank_linesync #(.SYNC(SYNC)) u_sync (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  dacbank_proto #(.NCH(NCH), .CW(CW), .DEV_ADDR(DEV_ADDR)) u_proto (
    .clk(clk), .rst(rst), .sda_s(sda_s), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
    .sda_oe(sda_oe_o), .clear_all(clear_all), .clear_one(clear_one),
    .clear_idx(clear_idx), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .full_rst(full_rst)
  );

  dacbank_regs #(.NCH(NCH), .CW(CW)) u_regs (
    .clk(clk), .rst(rst), .wipe(full_rst), .clear_all(clear_all),
    .clear_one(clear_one), .clear_idx(clear_idx), .wr_en(wr_en),
    .wr_idx(wr_idx), .wr_data(wr_data), .codes_o(codes_o)
  );
endmodule

// File: rtl/dacbank_chk.sv
module dacbank_chk #(
  parameter int  NCH = 8,
  parameter int  CW  = 10,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input logic              clk,
  input logic              rst,
  input logic              scl_fall,
  input logic              start_det,
  input logic              stop_det,
  input logic              sda_oe,
  input logic              clear_all,
  input logic              clear_one,
  input logic [CHW-1:0]    clear_idx,
  input logic              wr_en,
  input logic [CHW-1:0]    wr_idx,
  input logic [CW-1:0]     wr_data,
  input logic              full_rst,
  input logic [NCH*CW-1:0] codes
);
  localparam logic [CW-1:0]     MID    = {1'b1, {(CW-1){1'b0}}};
  localparam logic [NCH*CW-1:0] ALLMID = {NCH{MID}};

  logic rst_q;
  always_ff @(posedge clk) rst_q <= rst;

  always @(posedge clk)
    if (rst_q) a_r1_por_mid: assert (codes == ALLMID && !sda_oe);

  a_r11_ack_from_fall: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_oe) |-> $past(scl_fall));
  a_r11_release_on_edge: assert property (@(posedge clk) disable iff (rst)
    $fell(sda_oe) |-> $past(scl_fall || start_det || stop_det));
  a_r2_gc_wipe: assert property (@(posedge clk) disable iff (rst)
    full_rst |=> (codes == ALLMID));
  a_r5_clear_all: assert property (@(posedge clk) disable iff (rst)
    clear_all |=> (codes == ALLMID));

  for (genvar g = 0; g < NCH; g++) begin : g_chk
    a_r7_write_lands: assert property (@(posedge clk) disable iff (rst)
      (wr_en && wr_idx == CHW'(g) && !clear_all && !clear_one && !full_rst)
      |=> (codes[g*CW +: CW] == $past(wr_data)));
    a_r6_clear_one: assert property (@(posedge clk) disable iff (rst)
      (clear_one && clear_idx == CHW'(g)) |=> (codes[g*CW +: CW] == MID));
    a_r10_hold: assert property (@(posedge clk) disable iff (rst)
      !$stable(codes[g*CW +: CW]) |->
        $past(rst || full_rst || clear_all || clear_one || wr_en));
  end
endmodule

bind dacbank_i2c_target dacbank_chk #(.NCH(NCH), .CW(CW)) u_chk (
  .clk(clk), .rst(rst), .scl_fall(scl_fall), .start_det(start_det),
  .stop_det(stop_det), .sda_oe(sda_oe_o), .clear_all(clear_all),
  .clear_one(clear_one), .clear_idx(clear_idx), .wr_en(wr_en),
  .wr_idx(wr_idx), .wr_data(wr_data), .full_rst(full_rst), .codes(codes_o)
);

// File: tb/sim_dacbank_i2c_target.sv
module sim_dacbank_i2c_target;
  localparam int         NCH = 8;
  localparam int         CW  = 10;
  localparam logic [6:0] DEV = 7'h2A;
  localparam int         Q   = 20;
  localparam logic [CW-1:0] MID = 10'h200;

  logic clk = 1'b0, rst = 1'b1, scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe;
  logic [NCH*CW-1:0] codes;
  wire  sda_bus = sda_m & ~sda_oe;

  int vecs = 0, errs = 0;
  bit finished = 0;
  logic [CW-1:0] expc [NCH];

  always #4 clk = ~clk;

  dacbank_i2c_target #(.NCH(NCH), .CW(CW), .DEV_ADDR(DEV)) u0 (
    .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_bus),
    .sda_oe_o(sda_oe), .codes_o(codes)
  );

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(string tag, int act, int exp);
    vecs++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic check_bank(string tag);
    for (int i = 0; i < NCH; i++)
      check($sformatf("%s ch%0d", tag, i), int'(codes[i*CW +: CW]), int'(expc[i]));
  endtask

  task automatic bus_start();
    sda_m = 1'b1; scl_m = 1'b1; tick(Q);
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b1; tick(2*Q);
  endtask

  task automatic send(logic [7:0] b, bit exp_ack, string tag);
    bit got;
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; tick(Q);
      scl_m = 1'b1; tick(2*Q);
      scl_m = 1'b0; tick(Q);
    end
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; tick(Q);
    got = ~sda_bus;
    tick(Q);
    scl_m = 1'b0; tick(Q);
    check($sformatf("%s ack of %02h", tag, b), int'(got), int'(exp_ack));
    check("R11 SDA released after ack slot", int'(sda_oe), 0);
  endtask

  task automatic write_code(int ch, logic [CW-1:0] v);
    bus_start();
    send({DEV, 1'b0}, 1, "R9");
    send(8'(ch), 1, "R4");
    send({6'b0, v[9:8]}, 1, "R7");
    send(v[7:0], 1, "R7");
    bus_stop();
    expc[ch] = v;
  endtask

  task automatic t_reset();
    rst = 1'b1; tick(10);
    check("R1 sda_oe in reset", int'(sda_oe), 0);
    rst = 1'b0; tick(1);
    for (int i = 0; i < NCH; i++) expc[i] = MID;
    check_bank("R1 power-on mid-scale");
  endtask

  task automatic t_write();
    write_code(3, 10'h2AB);
    check_bank("R7 write ch3");
  endtask

  task automatic t_stream();
    bus_start();
    send({DEV, 1'b0}, 1, "R9");
    send(8'h07, 1, "R4");
    send(8'h00, 1, "R7");
    send(8'h01, 1, "R7");
    send(8'h00, 1, "R8 second command");
    send(8'hFE, 1, "R7");
    send(8'hFF, 1, "R7");
    bus_stop();
    expc[7] = 10'h001;
    expc[0] = 10'h2FF;
    check_bank("R8 streamed writes, R7 high bits ignored");
  endtask

  task automatic t_reset_one();
    bus_start();
    send({DEV, 1'b0}, 1, "R9");
    send(8'h43, 1, "R6");
    send(8'h01, 1, "R6");
    send(8'h55, 1, "R6");
    bus_stop();
    expc[3] = MID;
    check_bank("R6 reset one channel");
  endtask

  task automatic t_reset_all();
    write_code(1, 10'h155);
    check_bank("R7 write ch1");
    bus_start();
    send({DEV, 1'b0}, 1, "R9");
    send(8'h82, 1, "R5");
    for (int i = 0; i < NCH; i++) expc[i] = MID;
    check_bank("R5 bank cleared after command byte");
    send(8'h03, 1, "R5");
    send(8'h33, 1, "R5");
    bus_stop();
    check_bank("R5 trailing bytes discarded");
  endtask

  task automatic t_bad_sel();
    write_code(5, 10'h0AA);
    bus_start();
    send({DEV, 1'b0}, 1, "R9");
    send(8'h09, 0, "R4 channel out of range");
    send(8'h00, 0, "R4 skip after bad command");
    bus_stop();
    bus_start();
    send({DEV, 1'b0}, 1, "R9");
    send(8'h15, 0, "R4 bit4 set");
    bus_stop();
    bus_start();
    send({DEV, 1'b0}, 1, "R9");
    send(8'h65, 0, "R4 unknown command");
    bus_stop();
    check_bank("R4 bank untouched");
  endtask

  task automatic t_bad_addr();
    bus_start();
    send({7'h2B, 1'b0}, 0, "R9 wrong address");
    send(8'h05, 0, "R9 byte after wrong address");
    bus_stop();
    bus_start();
    send({DEV, 1'b1}, 0, "R9 read request");
    bus_stop();
    check_bank("R9 bank untouched");
  endtask

  task automatic t_gc_bad();
    bus_start();
    send(8'h00, 1, "R2 general call address");
    send(8'h05, 0, "R3 wrong general call data");
    bus_stop();
    check_bank("R3 no effect");
  endtask

  task automatic t_abort();
    bus_start();
    send({DEV, 1'b0}, 1, "R9");
    send(8'h02, 1, "R4");
    send(8'h01, 1, "R7");
    bus_stop();
    check_bank("R10 stop before low byte");
    bus_start();
    send({DEV, 1'b0}, 1, "R9");
    send(8'h04, 1, "R4");
    bus_start();
    send({DEV, 1'b0}, 1, "R10 address after restart");
    send(8'h04, 1, "R4");
    send(8'h02, 1, "R7");
    send(8'h34, 1, "R7");
    bus_stop();
    expc[4] = 10'h234;
    check_bank("R10 restart then write");
  endtask

  task automatic t_gc_good();
    bus_start();
    send(8'h00, 1, "R2 general call address");
    send(8'h06, 1, "R2 general call reset data");
    bus_stop();
    for (int i = 0; i < NCH; i++) expc[i] = MID;
    check_bank("R2 full reset");
    write_code(6, 10'h3C3);
    check_bank("R2 target usable after reset");
  endtask

  initial begin
    t_reset();
    t_write();
    t_stream();
    t_reset_one();
    t_reset_all();
    t_bad_sel();
    t_bad_addr();
    t_gc_bad();
    t_abort();
    t_gc_good();
    if (!finished) begin
      finished = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      vecs++;
      errs++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end
endmodule